// File: doc/BRIEF.md
# Rotating-Spare ADC Input Router

This block runs a bank of NCH+1 physical analog-to-digital converters so that NCH logical input streams are sampled without interruption, while one converter at a time is taken off input duty and fed from a reference DAC to be calibrated. For every converter it issues a three-way source choice: its own input, the input next below it, or the reference. It also routes the converter results onto the logical lanes and corrects each physical result with a host-supplied offset and gain. The reference DAC code is generated here, and the raw readings of the converter under calibration are summed per reference level for the host to turn into new coefficients.

The spare slot walks upward through the converters and wraps around. When a converter finishes calibration it rejoins input duty for a short handover window. During that window two converters observe the same input, and the affected lane carries the mean of their corrected values, so the stream never has a gap. All state changes happen on sample boundaries, marked by a one-cycle sample strobe that also carries the results of the interval just ended.

Top module: `spare_adc_router`

## Requirements
- R1: `adc_src` holds two bits per converter p at bits [2p+1:2p], with the codes 0 = input p, 1 = input p-1, 2 = reference; code 3 never appears. While converter k is being calibrated, converters below k use code 0, converter k uses code 2, and converters above k use code 1.
- R2: At most one converter selects the reference at any time. Exactly one does so during calibration, and none does during handover.
- R3: Outside the handover lane, logical lane j (bits [16j+15:16j] of `log_data`) carries converter j's corrected result when j < k, and converter j+1's corrected result otherwise.
- R4: A corrected result is floor((raw - offset) * gain / 2^15), saturated to [-32768, 32767]. Raw and offset are signed 16-bit values. Gain is an unsigned 17-bit value in which 32768 means unity.
- R5: `ref_code` is LO_CODE (-16000) for the CAL_LEN (4) samples of the low step, then HI_CODE (16000) for the CAL_LEN samples of the high step, and LO_CODE during handover. It changes only in the cycle after a sample strobe.
- R6: At the end of each step, the sum of the calibrated converter's raw readings over that step is latched (low step into `cal_lo`, high step into `cal_hi`). `cal_done` is a one-cycle pulse in the cycle after the final high-step strobe, with `cal_res_ch` giving the converter that was measured.
- R7: After the high step comes a handover of HAND_LEN (2) samples. The outgoing converter o takes code 0, or code 1 when o = NCH, and every other converter keeps its code. Lane h = min(o, NCH-1) carries floor((c[h] + c[h+1]) / 2) of the corrected results.
- R8: `cal_chan` reports the converter under calibration. It advances 0, 1, ..., NCH, 0 at the end of each handover and changes only in the cycle after a sample strobe.
- R9: `log_valid` is a one-cycle pulse two clocks after each sample strobe and is never raised otherwise.
- R10: In reset, `cal_chan` is 0, the low step is active, `log_valid` and `cal_done` are low, and `adc_src` is 8'b01010110 for NCH = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample boundary strobe; the raw results are valid with it |
| adc_raw | input | (NCH+1)*DW | Signed raw result per physical converter |
| off_coef | input | (NCH+1)*DW | Signed offset per physical converter |
| gain_coef | input | (NCH+1)*GW | Unsigned gain per physical converter, unity = 2^FRAC |
| adc_src | output | 2*(NCH+1) | Source selection per converter |
| ref_code | output | DW | Reference DAC code |
| log_valid | output | 1 | Logical lane results valid |
| log_data | output | NCH*DW | Corrected logical lanes |
| cal_chan | output | $clog2(NCH+1) | Converter currently under calibration |
| cal_done | output | 1 | Calibration sums updated for a converter |
| cal_res_ch | output | $clog2(NCH+1) | Converter the latched sums belong to |
| cal_lo | output | DW+$clog2(CAL_LEN)+1 | Sum of raw readings at the low reference code |
| cal_hi | output | DW+$clog2(CAL_LEN)+1 | Sum of raw readings at the high reference code |

## Verification
The sharpest collisions happen on the final high-step strobe, where the calibration sum is latched, the done pulse is raised, and the block moves into handover, all in the same sample. On the last handover strobe, the spare index advances while a lane is still being averaged. The bench runs several full rotations, so every converter goes through both collisions, including the wrap from the top converter back to zero. In each case it compares the lane values, the sums and the next source codes against a model that follows the requirements. Saturating coefficients are forced on a few samples so that clipping and averaging are judged in the same runs.

// File: rtl/spare_rt_pkg.sv
package spare_rt_pkg;
   typedef enum logic [1:0] {
      PH_LO   = 2'd0,
      PH_HI   = 2'd1,
      PH_HAND = 2'd2
   } phase_e;

   localparam logic [1:0] SRC_OWN  = 2'd0;
   localparam logic [1:0] SRC_PREV = 2'd1;
   localparam logic [1:0] SRC_REF  = 2'd2;
endpackage

// File: rtl/spr_rot_ctrl.sv
module spr_rot_ctrl
   import spare_rt_pkg::*;
#(
   parameter int NCH      = 3,
   parameter int DW       = 16,
   parameter int CAL_LEN  = 4,
   parameter int HAND_LEN = 2,
   parameter int LO_CODE  = -16000,
   parameter int HI_CODE  = 16000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   output phase_e                     phase,
   output logic [$clog2(NCH+1)-1:0]   chan,
   output logic                       last_smp,
   output logic [2*(NCH+1)-1:0]       adc_src,
   output logic [DW-1:0]              ref_code
);
   localparam int CIW  = $clog2(NCH+1);
   localparam int MAXL = (CAL_LEN > HAND_LEN) ? CAL_LEN : HAND_LEN;
   localparam int CNTW = $clog2(MAXL+1);

   logic [CNTW-1:0] cnt;
   logic            top_ch;

   assign top_ch   = (chan == CIW'(NCH));
   assign last_smp = (phase == PH_HAND) ? (cnt == CNTW'(HAND_LEN-1))
                                        : (cnt == CNTW'(CAL_LEN-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_LO;
         chan  <= '0;
         cnt   <= '0;
      end else if (smp_valid) begin
         if (last_smp) begin
            cnt <= '0;
            case (phase)
               PH_LO:   phase <= PH_HI;
               PH_HI:   phase <= PH_HAND;
               default: begin
                  phase <= PH_LO;
                  chan  <= top_ch ? '0 : chan + CIW'(1);
               end
            endcase
         end else begin
            cnt <= cnt + CNTW'(1);
         end
      end
   end

   for (genvar p = 0; p <= NCH; p++) begin : g_src
      logic [1:0] s;
      always_comb begin
         if (CIW'(p) < chan)
            s = SRC_OWN;
         else if (CIW'(p) > chan)
            s = SRC_PREV;
         else if (phase != PH_HAND)
            s = SRC_REF;
         else
            s = top_ch ? SRC_PREV : SRC_OWN;
      end
      assign adc_src[2*p +: 2] = s;
   end

   assign ref_code = (phase == PH_HI) ? DW'(HI_CODE) : DW'(LO_CODE);
endmodule

// File: rtl/spr_corr.sv
module spr_corr #(
   parameter int DW   = 16,
   parameter int GW   = 17,
   parameter int FRAC = 15
) (
   input  logic signed [DW-1:0] raw,
   input  logic signed [DW-1:0] off,
   input  logic        [GW-1:0] gain,
   output logic signed [DW-1:0] y
);
   localparam int PW = DW + GW + 2;
   localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW-1)) - 1);
   localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

   logic signed [DW:0]   diff;
   logic signed [GW:0]   g_s;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   assign diff    = {raw[DW-1], raw} - {off[DW-1], off};
   assign g_s     = {1'b0, gain};
   assign prod    = PW'(diff) * PW'(g_s);
   assign shifted = prod >>> FRAC;

   always_comb begin
      if (shifted > MAXV)
         y = MAXV[DW-1:0];
      else if (shifted < MINV)
         y = MINV[DW-1:0];
      else
         y = shifted[DW-1:0];
   end
endmodule

// File: rtl/spr_lane_mux.sv
module spr_lane_mux #(
   parameter int NCH = 3,
   parameter int DW  = 16
) (
   input  logic [(NCH+1)*DW-1:0]      corr,
   input  logic                       hand,
   input  logic [$clog2(NCH+1)-1:0]   chan,
   output logic [NCH*DW-1:0]          lanes
);
   localparam int CIW = $clog2(NCH+1);

   logic [CIW-1:0] hl;
   assign hl = (chan == CIW'(NCH)) ? CIW'(NCH-1) : chan;

   for (genvar j = 0; j < NCH; j++) begin : g_lane
      logic signed [DW-1:0] a, b;
      logic signed [DW:0]   s;
      logic                 avg;
      assign a   = corr[j*DW +: DW];
      assign b   = corr[(j+1)*DW +: DW];
      assign s   = {a[DW-1], a} + {b[DW-1], b};
      assign avg = hand && (hl == CIW'(j));
      assign lanes[j*DW +: DW] = avg ? s[DW:1] : ((CIW'(j) < chan) ? a : b);
   end
endmodule

// File: rtl/spr_cal_acc.sv
module spr_cal_acc
   import spare_rt_pkg::*;
#(
   parameter int NCH     = 3,
   parameter int DW      = 16,
   parameter int CAL_LEN = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   smp_valid,
   input  phase_e                                 phase,
   input  logic [$clog2(NCH+1)-1:0]               chan,
   input  logic                                   last_smp,
   input  logic [(NCH+1)*DW-1:0]                  adc_raw,
   output logic                                   cal_done,
   output logic [$clog2(NCH+1)-1:0]               cal_res_ch,
   output logic [DW+$clog2(CAL_LEN)+1-1:0]        cal_lo,
   output logic [DW+$clog2(CAL_LEN)+1-1:0]        cal_hi
);
   localparam int AW = DW + $clog2(CAL_LEN) + 1;

   logic signed [DW-1:0] rsel;
   logic signed [AW-1:0] rext, acc, sum;

   assign rsel = adc_raw[int'(chan)*DW +: DW];
   assign rext = AW'(rsel);
   assign sum  = acc + rext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= '0;
         cal_lo     <= '0;
         cal_hi     <= '0;
         cal_res_ch <= '0;
         cal_done   <= 1'b0;
      end else begin
         cal_done <= 1'b0;
         if (smp_valid && phase != PH_HAND) begin
            if (last_smp) begin
               acc <= '0;
               if (phase == PH_LO) begin
                  cal_lo <= sum;
               end else begin
                  cal_hi     <= sum;
                  cal_res_ch <= chan;
                  cal_done   <= 1'b1;
               end
            end else begin
               acc <= sum;
            end
         end
      end
   end
endmodule

// File: rtl/spare_adc_router.sv
module spare_adc_router
   import spare_rt_pkg::*;
#(
   parameter int NCH      = 3,
   parameter int DW       = 16,
   parameter int GW       = 17,
   parameter int FRAC     = 15,
   parameter int CAL_LEN  = 4,
   parameter int HAND_LEN = 2,
   parameter int LO_CODE  = -16000,
   parameter int HI_CODE  = 16000
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   smp_valid,
   input  logic [(NCH+1)*DW-1:0]                  adc_raw,
   input  logic [(NCH+1)*DW-1:0]                  off_coef,
   input  logic [(NCH+1)*GW-1:0]                  gain_coef,
   output logic [2*(NCH+1)-1:0]                   adc_src,
   output logic [DW-1:0]                          ref_code,
   output logic                                   log_valid,
   output logic [NCH*DW-1:0]                      log_data,
   output logic [$clog2(NCH+1)-1:0]               cal_chan,
   output logic                                   cal_done,
   output logic [$clog2(NCH+1)-1:0]               cal_res_ch,
   output logic [DW+$clog2(CAL_LEN)+1-1:0]        cal_lo,
   output logic [DW+$clog2(CAL_LEN)+1-1:0]        cal_hi
);
   localparam int NPH = NCH + 1;
   localparam int CIW = $clog2(NPH);

   if (NCH < 1)                 begin : g_bad_nch  $error("NCH must be at least 1");          end
   if (DW < 4 || DW > 24)       begin : g_bad_dw   $error("DW must lie in 4..24");            end
   if (FRAC < 1 || FRAC >= GW)  begin : g_bad_frac $error("FRAC must lie in 1..GW-1");        end
   if (CAL_LEN < 1)             begin : g_bad_cal  $error("CAL_LEN must be at least 1");      end
   if (HAND_LEN < 1)            begin : g_bad_hand $error("HAND_LEN must be at least 1");     end

   phase_e         phase;
   logic           last_smp;
   logic [NPH*DW-1:0] corr_w, corr_q;
   logic [NCH*DW-1:0] lane_w;
   logic           va, hand_q;
   logic [CIW-1:0] chan_q;

   spr_rot_ctrl #(
      .NCH(NCH), .DW(DW), .CAL_LEN(CAL_LEN), .HAND_LEN(HAND_LEN),
      .LO_CODE(LO_CODE), .HI_CODE(HI_CODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .phase(phase), .chan(cal_chan), .last_smp(last_smp),
      .adc_src(adc_src), .ref_code(ref_code)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_corr
      spr_corr #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_corr (
         .raw (adc_raw[p*DW +: DW]),
         .off (off_coef[p*DW +: DW]),
         .gain(gain_coef[p*GW +: GW]),
         .y   (corr_w[p*DW +: DW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va     <= 1'b0;
         hand_q <= 1'b0;
         chan_q <= '0;
         corr_q <= '0;
      end else begin
         va <= smp_valid;
         if (smp_valid) begin
            corr_q <= corr_w;
            hand_q <= (phase == PH_HAND);
            chan_q <= cal_chan;
         end
      end
   end

   spr_lane_mux #(.NCH(NCH), .DW(DW)) u_mux (
      .corr(corr_q), .hand(hand_q), .chan(chan_q), .lanes(lane_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_valid <= 1'b0;
         log_data  <= '0;
      end else begin
         log_valid <= va;
         if (va)
            log_data <= lane_w;
      end
   end

   spr_cal_acc #(.NCH(NCH), .DW(DW), .CAL_LEN(CAL_LEN)) u_acc (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .phase(phase), .chan(cal_chan), .last_smp(last_smp),
      .adc_raw(adc_raw),
      .cal_done(cal_done), .cal_res_ch(cal_res_ch),
      .cal_lo(cal_lo), .cal_hi(cal_hi)
   );
endmodule

// File: rtl/spare_adc_router_chk.sv
module spare_adc_router_chk #(
   parameter int NCH = 3,
   parameter int DW  = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       smp_valid,
   input logic [2*(NCH+1)-1:0]       adc_src,
   input logic [DW-1:0]              ref_code,
   input logic                       log_valid,
   input logic [$clog2(NCH+1)-1:0]   cal_chan,
   input logic                       cal_done
);
   logic [NCH:0] ref_mask, bad_mask;

   always_comb begin
      for (int p = 0; p <= NCH; p++) begin
         ref_mask[p] = (adc_src[2*p +: 2] == 2'd2);
         bad_mask[p] = (adc_src[2*p +: 2] == 2'd3);
      end
   end

   // R1
   src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mask == '0);

   // R2
   one_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ref_mask));

   // R5
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_code) |-> $past(smp_valid));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   // R8
   chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cal_chan) |-> $past(smp_valid));

   // R8
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cal_chan) <= NCH);

   // R9
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> $past(smp_valid, 2));

   // R9
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> ##2 log_valid);
endmodule

bind spare_adc_router spare_adc_router_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .adc_src(adc_src),
   .ref_code(ref_code), .log_valid(log_valid), .cal_chan(cal_chan),
   .cal_done(cal_done)
);

// File: tb/sim_spare_adc_router.sv
`timescale 1ns/1ps
module sim_spare_adc_router;
   localparam int NCH = 3, DW = 16, GW = 17, CAL_LEN = 4, HAND_LEN = 2;
   localparam int LO = -16000, HI = 16000;
   localparam int NPH = NCH + 1, CIW = 2, AW = DW + 2 + 1;

   logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
   logic [NPH*DW-1:0] adc_raw = '0, off_coef = '0;
   logic [NPH*GW-1:0] gain_coef = '0;
   logic [2*NPH-1:0]  adc_src;
   logic [DW-1:0]     ref_code;
   logic              log_valid, cal_done;
   logic [NCH*DW-1:0] log_data;
   logic [CIW-1:0]    cal_chan, cal_res_ch;
   logic [AW-1:0]     cal_lo, cal_hi;

   always #2 clk = ~clk;

   spare_adc_router u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .adc_raw(adc_raw),
      .off_coef(off_coef), .gain_coef(gain_coef), .adc_src(adc_src),
      .ref_code(ref_code), .log_valid(log_valid), .log_data(log_data),
      .cal_chan(cal_chan), .cal_done(cal_done), .cal_res_ch(cal_res_ch),
      .cal_lo(cal_lo), .cal_hi(cal_hi)
   );

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   int raw_a[NPH], off_a[NPH], gain_a[NPH];
   int m_ph = 0, m_k = 0, m_cnt = 0;
   longint m_acc = 0, e_lo = 0, e_hi = 0;

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int fcorr(int r, int o, int g);
      longint d = longint'(r) - longint'(o);
      longint s = (d * longint'(g)) >>> 15;
      if (s > 32767) return 32767;
      if (s < -32768) return -32768;
      return int'(s);
   endfunction

   function automatic int esrc(int p);
      if (p < m_k) return 0;
      if (p > m_k) return 1;
      if (m_ph != 2) return 2;
      return (m_k == NCH) ? 1 : 0;
   endfunction

   task automatic do_sample(string ltag);
      int corr_e[NPH];
      int lane_e[NCH];
      int nref, hl, k_old;
      bit done_e, hand;
      longint sum;
      @(negedge clk);
      nref = 0;
      for (int p = 0; p < NPH; p++) begin
         chk("R1", $sformatf("adc_src[%0d]", p), adc_src[2*p +: 2], esrc(p));
         if (adc_src[2*p +: 2] == 2'd2) nref++;
      end
      chk("R2", "reference count", nref, (m_ph == 2) ? 0 : 1);
      chk("R5", "ref_code", $signed(ref_code), (m_ph == 1) ? HI : LO);
      chk("R8", "cal_chan", cal_chan, m_k);
      for (int p = 0; p < NPH; p++) begin
         adc_raw[p*DW +: DW]   = DW'(raw_a[p]);
         off_coef[p*DW +: DW]  = DW'(off_a[p]);
         gain_coef[p*GW +: GW] = GW'(gain_a[p]);
      end
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      for (int p = 0; p < NPH; p++) corr_e[p] = fcorr(raw_a[p], off_a[p], gain_a[p]);
      hand = (m_ph == 2);
      hl = (m_k == NCH) ? NCH - 1 : m_k;
      for (int j = 0; j < NCH; j++) begin
         if (hand && j == hl) lane_e[j] = (corr_e[j] + corr_e[j+1]) >>> 1;
         else if (j < m_k)    lane_e[j] = corr_e[j];
         else                 lane_e[j] = corr_e[j+1];
      end
      done_e = (m_ph == 1) && (m_cnt == CAL_LEN - 1);
      k_old = m_k;
      if (m_ph != 2) begin
         sum = m_acc + longint'(raw_a[m_k]);
         if (m_cnt == CAL_LEN - 1) begin
            if (m_ph == 0) e_lo = sum; else e_hi = sum;
            m_acc = 0;
         end else m_acc = sum;
      end
      if ((m_ph == 2 && m_cnt == HAND_LEN - 1) || (m_ph != 2 && m_cnt == CAL_LEN - 1)) begin
         m_cnt = 0;
         if (m_ph == 2) begin
            m_ph = 0;
            m_k = (m_k == NCH) ? 0 : m_k + 1;
         end else m_ph = m_ph + 1;
      end else m_cnt++;
      chk("R6", "cal_done", cal_done, done_e);
      if (done_e) begin
         chk("R6", "cal_lo", $signed(cal_lo), e_lo);
         chk("R6", "cal_hi", $signed(cal_hi), e_hi);
         chk("R6", "cal_res_ch", cal_res_ch, k_old);
      end
      @(negedge clk);
      chk("R9", "log_valid pulse", log_valid, 1);
      chk("R6", "cal_done low after pulse", cal_done, 0);
      for (int j = 0; j < NCH; j++)
         chk((hand && j == hl) ? "R7" : ltag, $sformatf("lane %0d", j),
             $signed(log_data[j*DW +: DW]), lane_e[j]);
      @(negedge clk);
      chk("R9", "log_valid idle", log_valid, 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5eed);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "reset log_valid", log_valid, 0);
      chk("R10", "reset cal_done", cal_done, 0);
      chk("R10", "reset cal_chan", cal_chan, 0);
      chk("R10", "reset adc_src", adc_src, 8'b01010110);
      chk("R10", "reset ref_code", $signed(ref_code), LO);
      rst_n = 1'b1;
      for (int i = 0; i < 130; i++) begin
         string tag;
         tag = "R3";
         if (i % 10 == 0)
            for (int p = 0; p < NPH; p++) begin
               off_a[p]  = $urandom_range(0, 2000) - 1000;
               gain_a[p] = 16384 + $urandom_range(0, 65535);
            end
         for (int p = 0; p < NPH; p++) raw_a[p] = $urandom_range(0, 65535) - 32768;
         if (i == 5 || i == 47) begin
            tag = "R4";
            for (int p = 0; p < NPH; p++) begin raw_a[p] = 32767; off_a[p] = -32768; gain_a[p] = 131071; end
         end else if (i == 6 || i == 48) begin
            tag = "R4";
            for (int p = 0; p < NPH; p++) begin raw_a[p] = -32768; off_a[p] = 32767; gain_a[p] = 131071; end
         end else if (i == 7) begin
            tag = "R4";
            for (int p = 0; p < NPH; p++) begin off_a[p] = 5; gain_a[p] = 32768; end
         end
         do_sample(tag);
         if (i % 7 == 3) repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule